// File: doc/BRIEF.md
# Parallel Two-Bit-Correcting BCH Decoder

This block corrects up to two flipped bits in a 274-bit codeword made of 256 data bits and 18 check bits. The code is a shortened binary BCH code over GF(2^9), built from the field polynomial x^9 + x^4 + 1. The whole decode runs in one combinational pass with no iteration, followed by an optional output register. It computes two syndromes. It forms a scaled error locator with no field inversion. It tests every bit position for a root at once and flips the data bits it finds.

A read path places the decoder right after the storage array. Each clock it receives one whole codeword and returns the repaired data. Exactly one of three flags is set with the data: clean, corrected, or uncorrectable.

Top module: `bch2_dec_par`

## Requirements
- R1: Codeword bit i is the coefficient of x^i. Bits 17..0 hold the check bits and bits 273..18 hold data bits 255..0. A valid word is a multiple of the product of the minimal polynomials of alpha and alpha^3, where alpha is a root of x^9 + x^4 + 1.
- R2: A valid codeword gives ok_o = 1 and data_o equal to its data field unchanged.
- R3: A codeword with one flipped bit at any of the 274 positions gives fixed_o = 1 and the original data.
- R4: A codeword with two flipped bits at any two distinct positions gives fixed_o = 1 and the original data.
- R5: A codeword with three flipped bits never gives ok_o = 1. When it gives fixed_o = 1, data_o is the data of a valid codeword within Hamming distance 2 of the received word.
- R6: When bad_o = 1, data_o equals the received data field with no bit flipped.
- R7: After the first loaded cycle, exactly one of ok_o, fixed_o and bad_o is high in every cycle.
- R8: With REG_OUT = 1 the outputs follow the input one clock later. While rst_n is low, data_o and all three flags are zero.
- R9: Flipped bits that lie only in the check field (positions 0..17) leave data_o equal to the original data, and fixed_o = 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the output register |
| rst_n | input | 1 | Asynchronous active-low reset |
| cw_i | input | 274 | Received codeword, check bits in the low 18 bits |
| data_o | output | 256 | Corrected data field |
| ok_o | output | 1 | Codeword was free of errors |
| fixed_o | output | 1 | One or two errors were located and repaired |
| bad_o | output | 1 | Error pattern beyond repair, data passed through |

## Verification
Data correction and the root count over the check field take part in the same evaluation. When one flip lands in the data field and the other in the check field, the root that marks the check bit decides whether the word is accepted, yet it must not alter any data bit. The bench provokes this with directed pairs that straddle the boundary at positions 17 and 18, with pairs that lie wholly in the check field, and with random pairs. It judges each case by comparing data_o with the original data and requiring fixed_o alone to be high.

// File: rtl/bch2_dec_par.sv
`timescale 1ns/1ps
module bch2_dec_par #(
  parameter int DATA_W = 256,
  parameter int M = 9,
  parameter logic [8:0] POLY = 9'h011,
  parameter bit REG_OUT = 1'b1
)(
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [DATA_W+2*M-1:0]   cw_i,
  output logic [DATA_W-1:0]       data_o,
  output logic                    ok_o,
  output logic                    fixed_o,
  output logic                    bad_o
);
  localparam int N   = DATA_W + 2*M;
  localparam int ORD = (1 << M) - 1;
  localparam int CW  = $clog2(N + 1);

  function automatic logic [M-1:0] gmul(input logic [M-1:0] a, input logic [M-1:0] b);
    logic [M-1:0] p, x;
    p = '0;
    x = a;
    for (int k = 0; k < M; k++) begin
      if (b[k]) p ^= x;
      x = x[M-1] ? ({x[M-2:0], 1'b0} ^ POLY[M-1:0]) : {x[M-2:0], 1'b0};
    end
    return p;
  endfunction

  function automatic logic [M-1:0] apow(input int e);
    logic [M-1:0] r, b;
    int k;
    r = M'(1);
    b = M'(2);
    k = e % ORD;
    for (int j = 0; j < 16; j++) begin
      if (k[j]) r = gmul(r, b);
      b = gmul(b, b);
    end
    return r;
  endfunction

  logic [M-1:0]  s1, s3, s1sq, dd;
  logic [M-1:0]  pw1 [N];
  logic [M-1:0]  pw3 [N];
  logic [N-1:0]  root;
  logic [CW-1:0] nroot;
  logic          clean_c, fix_c, bad_c;
  logic [DATA_W-1:0] dat_c;

  for (genvar i = 0; i < N; i++) begin : g_pos
    localparam logic [M-1:0] P1 = apow(i);
    localparam logic [M-1:0] P3 = apow(3*i);
    localparam logic [M-1:0] Q1 = apow(ORD - (i % ORD));
    localparam logic [M-1:0] Q2 = apow(2*(ORD - (i % ORD)));
    assign pw1[i]  = P1;
    assign pw3[i]  = P3;
    assign root[i] = (s1 != '0) && ((s1 ^ gmul(s1sq, Q1) ^ gmul(dd, Q2)) == '0);
  end

  always_comb begin
    s1 = '0;
    s3 = '0;
    for (int i = 0; i < N; i++) begin
      if (cw_i[i]) begin
        s1 ^= pw1[i];
        s3 ^= pw3[i];
      end
    end
  end

  assign s1sq    = gmul(s1, s1);
  assign dd      = s3 ^ gmul(s1sq, s1);
  assign nroot   = CW'($countones(root));
  assign clean_c = (s1 == '0) && (s3 == '0);
  assign fix_c   = (s1 != '0) && (nroot == ((dd == '0) ? CW'(1) : CW'(2)));
  assign bad_c   = !clean_c && !fix_c;
  assign dat_c   = cw_i[N-1:2*M] ^ (fix_c ? root[N-1:2*M] : '0);

  if (REG_OUT) begin : g_reg
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        data_o  <= '0;
        ok_o    <= 1'b0;
        fixed_o <= 1'b0;
        bad_o   <= 1'b0;
      end else begin
        data_o  <= dat_c;
        ok_o    <= clean_c;
        fixed_o <= fix_c;
        bad_o   <= bad_c;
      end
    end
  end else begin : g_comb
    assign data_o  = dat_c;
    assign ok_o    = clean_c;
    assign fixed_o = fix_c;
    assign bad_o   = bad_c;
  end
endmodule

// File: rtl/bch2_dec_par_chk.sv
`timescale 1ns/1ps
module bch2_dec_par_chk #(
  parameter int DATA_W = 256,
  parameter int M = 9,
  parameter bit REG_OUT = 1'b1
)(
  input logic                  clk,
  input logic                  rst_n,
  input logic [DATA_W+2*M-1:0] cw_i,
  input logic [DATA_W-1:0]     data_o,
  input logic                  ok_o,
  input logic                  fixed_o,
  input logic                  bad_o
);
  logic [DATA_W-1:0] held_q, ref_d;
  logic              seen_q;

  always_ff @(posedge clk) held_q <= cw_i[DATA_W+2*M-1:2*M];
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) seen_q <= 1'b0;
    else        seen_q <= 1'b1;

  assign ref_d = REG_OUT ? held_q : cw_i[DATA_W+2*M-1:2*M];

  // R7
  one_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    seen_q |-> $countones({ok_o, fixed_o, bad_o}) == 1);
  // R2
  clean_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (seen_q && ok_o) |-> data_o == ref_d);
  // R6
  bad_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (seen_q && bad_o) |-> data_o == ref_d);
  // R4
  fix_span_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (seen_q && fixed_o) |-> $countones(data_o ^ ref_d) <= 2);
  // R8
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (seen_q && $stable(cw_i)) |=> $stable(data_o));
endmodule

bind bch2_dec_par bch2_dec_par_chk #(.DATA_W(DATA_W), .M(M), .REG_OUT(REG_OUT)) u_chk (.*);

// File: tb/sim_bch2_dec_par.sv
`timescale 1ns/1ps
module sim_bch2_dec_par;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [273:0] cw = '0;
  logic [255:0] data_o;
  logic         ok_o, fixed_o, bad_o;
  int           n_run = 0, n_fail = 0;
  logic [17:0]  gbits;

  always #2.5 clk = ~clk;

  bch2_dec_par u0 (.clk(clk), .rst_n(rst_n), .cw_i(cw), .data_o(data_o),
                   .ok_o(ok_o), .fixed_o(fixed_o), .bad_o(bad_o));

  function automatic logic [8:0] gm(input logic [8:0] a, input logic [8:0] b);
    logic [8:0] p = '0, x = a;
    for (int k = 0; k < 9; k++) begin
      if (b[k]) p ^= x;
      x = x[8] ? ({x[7:0], 1'b0} ^ 9'h011) : {x[7:0], 1'b0};
    end
    return p;
  endfunction

  function automatic logic [8:0] ap(input int e);
    logic [8:0] r = 9'd1;
    for (int k = 0; k < e; k++) r = gm(r, 9'd2);
    return r;
  endfunction

  function automatic logic [273:0] enc(input logic [255:0] d);
    logic [17:0] rem = '0;
    logic fb;
    for (int i = 255; i >= 0; i--) begin
      fb  = d[i] ^ rem[17];
      rem = {rem[16:0], 1'b0} ^ (fb ? gbits : 18'd0);
    end
    return {d, rem};
  endfunction

  function automatic logic [255:0] rdata();
    return {$urandom, $urandom, $urandom, $urandom, $urandom, $urandom, $urandom, $urandom};
  endfunction

  task automatic chk(input bit good, input string req, input string what,
                     input logic [273:0] act, input logic [273:0] exp);
    n_run++;
    if (!good) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic apply(input logic [273:0] c);
    @(negedge clk) cw = c;
    @(negedge clk);
  endtask

  task automatic expect_fix(input logic [255:0] d, input string req);
    chk(data_o == d, req, "data", 274'(data_o), 274'(d));
    chk({ok_o, fixed_o, bad_o} == 3'b010, req, "flags", 274'({ok_o, fixed_o, bad_o}), 274'(3'b010));
  endtask

  task automatic build_gen();
    logic [8:0] gp [0:18];
    int e;
    for (int j = 0; j <= 18; j++) gp[j] = '0;
    gp[0] = 9'd1;
    foreach (e_list[c]) begin
      e = e_list[c];
      for (int k = 0; k < 9; k++) begin
        for (int j = 18; j >= 1; j--) gp[j] = gp[j-1] ^ gm(gp[j], ap(e));
        gp[0] = gm(gp[0], ap(e));
        e = (e * 2) % 511;
      end
    end
    for (int j = 0; j < 18; j++) gbits[j] = gp[j][0];
    // R1: generator must be binary with unit leading term
    chk(gp[18] == 9'd1, "R1", "generator top", 274'(gp[18]), 274'(1));
  endtask
  int e_list [2] = '{1, 3};

  task automatic t_reset();
    cw = enc(rdata());
    repeat (3) @(negedge clk);
    // R8 reset state
    chk(data_o == '0 && {ok_o, fixed_o, bad_o} == 3'b000, "R8", "reset", 274'({data_o, ok_o, fixed_o, bad_o}), 274'(0));
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic t_clean();
    logic [255:0] d;
    for (int n = 0; n < 6; n++) begin
      d = (n == 0) ? '0 : (n == 1) ? '1 : rdata();
      apply(enc(d));
      chk(data_o == d, "R2", "clean data", 274'(data_o), 274'(d));
      chk({ok_o, fixed_o, bad_o} == 3'b100, "R2", "clean flags", 274'({ok_o, fixed_o, bad_o}), 274'(3'b100));
    end
  endtask

  task automatic t_latency();
    logic [255:0] a = rdata(), b = rdata();
    apply(enc(a));
    @(negedge clk) cw = enc(b);
    #1;
    chk(data_o == a, "R8", "held before edge", 274'(data_o), 274'(a));
    @(negedge clk);
    chk(data_o == b, "R8", "after edge", 274'(data_o), 274'(b));
  endtask

  task automatic t_single();
    logic [255:0] d = rdata();
    logic [273:0] c = enc(d);
    for (int i = 0; i < 274; i++) begin
      apply(c ^ (274'(1) << i));
      expect_fix(d, "R3");
    end
  endtask

  task automatic t_parity();
    logic [255:0] d = rdata();
    logic [273:0] c = enc(d);
    for (int i = 0; i < 17; i++) begin
      apply(c ^ (274'(1) << i) ^ (274'(1) << (i + 1)));
      expect_fix(d, "R9");
    end
  endtask

  task automatic t_double();
    logic [255:0] d;
    int i, j;
    int ei [4] = '{0, 17, 272, 17};
    int ej [4] = '{273, 18, 273, 200};
    for (int n = 0; n < 4; n++) begin
      d = rdata();
      apply(enc(d) ^ (274'(1) << ei[n]) ^ (274'(1) << ej[n]));
      expect_fix(d, "R4");
    end
    for (int n = 0; n < 300; n++) begin
      d = rdata();
      i = $urandom_range(273, 0);
      do j = $urandom_range(273, 0); while (j == i);
      apply(enc(d) ^ (274'(1) << i) ^ (274'(1) << j));
      expect_fix(d, "R4");
    end
  endtask

  task automatic t_triple();
    logic [255:0] d;
    logic [273:0] r;
    int i, j, k;
    for (int n = 0; n < 200; n++) begin
      d = rdata();
      i = $urandom_range(273, 0);
      do j = $urandom_range(273, 0); while (j == i);
      do k = $urandom_range(273, 0); while (k == i || k == j);
      r = enc(d) ^ (274'(1) << i) ^ (274'(1) << j) ^ (274'(1) << k);
      apply(r);
      chk(!ok_o, "R5", "not clean", 274'(ok_o), 274'(0));
      chk($countones({ok_o, fixed_o, bad_o}) == 1, "R7", "one flag", 274'({ok_o, fixed_o, bad_o}), 274'(1));
      if (bad_o)
        chk(data_o == r[273:18], "R6", "passthrough", 274'(data_o), 274'(r[273:18]));
      if (fixed_o)
        chk($countones(enc(data_o) ^ r) <= 2, "R5", "near codeword", 274'($countones(enc(data_o) ^ r)), 274'(2));
    end
  endtask

  initial begin
    #(5.0 * 150000);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'd7));
    build_gen();
    t_reset();
    t_clean();
    t_latency();
    t_single();
    t_parity();
    t_double();
    t_triple();
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule